// File: doc/BRIEF.md
# Dual-Clock Mixed-Width FIFO

This block is a first-in first-out buffer that moves data from a write clock domain to an unrelated read clock domain. The two ports may differ in width by a power-of-two ratio. When a written word is wider than a read word, the word is handed out over several reads, lowest slice first. When a read word is wider, several writes are gathered into one read word, and the earliest write forms the lowest slice. If the two widths are equal, the block is an ordinary single-width FIFO.

Each domain keeps a binary pointer in its own word units. A Gray-coded copy of that pointer goes to the other domain through a two-flop synchronizer. Each side then derives its own occupancy count, full flag and empty flag from its local pointer and the synchronized remote one. A write is governed by the write-side full flag and a read by the read-side empty flag. The read-side full flag and the write-side empty flag are delayed views meant for monitoring. One early-warning threshold applies on each side: almost-full on the write side and almost-empty on the read side.

Top module: `cdc_mixed_fifo`

## Requirements
- R1: While either reset is held, and after it is released with no traffic, both sides report empty, not full, almost-full low, almost-empty high and a level of zero.
- R2: Data leaves in the order it was written. A read that is accepted because `rd_empty` is low updates `rd_data` at the next `rd_clk` edge. A wide write word (32 bits by default, four 8-bit slices) is read out from bits [7:0] upward.
- R3: A write attempted while `wr_full` is high is ignored. No stored word changes and `wr_level` is unchanged.
- R4: A read attempted while `rd_empty` is high is ignored. `rd_data` and the read pointer keep their values.
- R5: `wr_level` counts write words that are still occupied, and a partly read word counts as occupied. `wr_full` is high exactly when `wr_level` equals 2**WR_AW.
- R6: `rd_level` counts the complete read words available. `rd_empty` is high exactly when `rd_level` is zero.
- R7: `rd_full` is computed from the read domain's synchronized copy of the write pointer. Once traffic has stopped and synchronization has settled, it equals `wr_full`. Each Gray pointer changes by at most one bit per clock.
- R8: `wr_empty` is computed from the write domain's synchronized copy of the read pointer. Once traffic has stopped and synchronization has settled, it equals `rd_empty`.
- R9: `wr_almost_full` is high when `wr_level` >= AFULL_AT.
- R10: `rd_almost_empty` is high when `rd_level` < AEMPTY_BELOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| wr_rst | input | 1 | Write domain reset, active high, asynchronous assert |
| wr_en | input | 1 | Write request |
| wr_data | input | WR_W | Write word |
| wr_full | output | 1 | Full; writes are refused while high |
| wr_empty | output | 1 | Delayed view of the empty condition |
| wr_almost_full | output | 1 | wr_level at or above AFULL_AT |
| wr_level | output | WR_AW+1 | Occupied write words |
| rd_clk | input | 1 | Read domain clock |
| rd_rst | input | 1 | Read domain reset, active high, asynchronous assert |
| rd_en | input | 1 | Read request |
| rd_data | output | RD_W | Read word, registered |
| rd_full | output | 1 | Delayed view of the full condition |
| rd_empty | output | 1 | Empty; reads are refused while high |
| rd_almost_empty | output | 1 | rd_level below AEMPTY_BELOW |
| rd_level | output | WR_AW+log2(WR_W/RD_W)+1 | Available read words (default 6 bits) |

## Verification
The results settle on three timescales. A local effect appears one clock of its own domain after the request: the level in that domain, the local full or empty flag, or `rd_data`. A remote effect needs the Gray register and two synchronizer stages, so it appears about three clocks of the observing domain later. The bench drives inputs and samples outputs on falling edges. It checks `rd_data` one read clock after each accepted read. It compares the levels and all flags with its queue model only after a quiet gap of several cycles in both domains.

// File: rtl/cdc_mixed_fifo.sv
module cdc_mixed_fifo #(
  parameter int WR_W         = 32,
  parameter int RD_W         = 8,
  parameter int WR_AW        = 3,
  parameter int AFULL_AT     = 6,
  parameter int AEMPTY_BELOW = 3
) (
  input  logic                   wr_clk,
  input  logic                   wr_rst,
  input  logic                   wr_en,
  input  logic [WR_W-1:0]        wr_data,
  output logic                   wr_full,
  output logic                   wr_empty,
  output logic                   wr_almost_full,
  output logic [WR_AW:0]         wr_level,
  input  logic                   rd_clk,
  input  logic                   rd_rst,
  input  logic                   rd_en,
  output logic [RD_W-1:0]        rd_data,
  output logic                   rd_full,
  output logic                   rd_empty,
  output logic                   rd_almost_empty,
  output logic [WR_AW+((WR_W>RD_W)?$clog2(WR_W/RD_W):0)-((RD_W>WR_W)?$clog2(RD_W/WR_W):0):0] rd_level
);
  localparam int MIN_W = (WR_W < RD_W) ? WR_W : RD_W;
  localparam int WSL   = WR_W / MIN_W;
  localparam int RSL   = RD_W / MIN_W;
  localparam int WSH   = $clog2(WSL);
  localparam int RSH   = $clog2(RSL);
  localparam int SA    = WR_AW + WSH;
  localparam int RA    = SA - RSH;
  localparam int WDEPTH = 1 << WR_AW;
  localparam int RDEPTH = 1 << RA;

  function automatic logic [WR_AW:0] wb2g(input logic [WR_AW:0] b);
    return b ^ (b >> 1);
  endfunction
  function automatic logic [RA:0] rb2g(input logic [RA:0] b);
    return b ^ (b >> 1);
  endfunction
  function automatic logic [WR_AW:0] wg2b(input logic [WR_AW:0] g);
    logic [WR_AW:0] b;
    b[WR_AW] = g[WR_AW];
    for (int i = WR_AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
  function automatic logic [RA:0] rg2b(input logic [RA:0] g);
    logic [RA:0] b;
    b[RA] = g[RA];
    for (int i = RA - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [1:0] wrs, rrs;
  logic wrst, rrst;
  always_ff @(posedge wr_clk or posedge wr_rst)
    if (wr_rst) wrs <= 2'b11; else wrs <= {wrs[0], 1'b0};
  always_ff @(posedge rd_clk or posedge rd_rst)
    if (rd_rst) rrs <= 2'b11; else rrs <= {rrs[0], 1'b0};
  assign wrst = wrs[1];
  assign rrst = rrs[1];

  logic [MIN_W-1:0] mem [0:(1<<SA)-1];
  logic [WR_AW:0] wptr, wgray, rg_s1_dummy_unused;
  logic [RA:0]    rptr, rgray;
  logic [RA:0]    rg_s1, rg_s2;
  logic [WR_AW:0] wg_s1, wg_s2;
  logic [SA:0]    w_c, r_c, wsync_c, rsync_c;
  logic wr_ok, rd_ok;

  assign rg_s1_dummy_unused = '0;

  assign w_c     = (SA+1)'(wptr) << WSH;
  assign r_c     = (SA+1)'(rptr) << RSH;
  assign wsync_c = (SA+1)'(wg2b(wg_s2)) << WSH;
  assign rsync_c = (SA+1)'(rg2b(rg_s2)) << RSH;

  assign wr_level       = wptr - (WR_AW+1)'(rsync_c >> WSH);
  assign wr_full        = (wr_level == (WR_AW+1)'(WDEPTH));
  assign wr_empty       = ((RA+1)'(w_c >> RSH) - (RA+1)'(rsync_c >> RSH)) == '0;
  assign wr_almost_full = (32'(wr_level) >= AFULL_AT);
  assign wr_ok          = wr_en && !wr_full;

  assign rd_level        = (RA+1)'(wsync_c >> RSH) - rptr;
  assign rd_empty        = (rd_level == '0);
  assign rd_full         = ((WR_AW+1)'(wsync_c >> WSH) - (WR_AW+1)'(r_c >> WSH)) == (WR_AW+1)'(WDEPTH);
  assign rd_almost_empty = (32'(rd_level) < AEMPTY_BELOW);
  assign rd_ok           = rd_en && !rd_empty;

  always_ff @(posedge wr_clk)
    if (wr_ok)
      for (int k = 0; k < WSL; k++)
        mem[(SA'(wptr[WR_AW-1:0]) << WSH) | SA'(k)] <= wr_data[k*MIN_W +: MIN_W];

  always_ff @(posedge wr_clk or posedge wrst)
    if (wrst) begin
      wptr  <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (wr_ok) begin
        wptr  <= wptr + 1'b1;
        wgray <= wb2g(wptr + 1'b1);
      end
    end

  always_ff @(posedge rd_clk or posedge rrst)
    if (rrst) begin
      rptr    <= '0;
      rgray   <= '0;
      wg_s1   <= '0;
      wg_s2   <= '0;
      rd_data <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      if (rd_ok) begin
        rptr  <= rptr + 1'b1;
        rgray <= rb2g(rptr + 1'b1);
        for (int k = 0; k < RSL; k++)
          rd_data[k*MIN_W +: MIN_W] <= mem[(SA'(rptr[RA-1:0]) << RSH) | SA'(k)];
      end
    end

  a_r3_full_write_ignored: assert property (@(posedge wr_clk) disable iff (wrst)
    (wr_en && wr_full) |=> $stable(wptr));
  a_r5_level_bound: assert property (@(posedge wr_clk) disable iff (wrst)
    32'(wr_level) <= WDEPTH);
  a_r7_wgray_step: assert property (@(posedge wr_clk) disable iff (wrst)
    $countones(wgray ^ $past(wgray)) <= 1);
  a_r4_empty_read_ignored: assert property (@(posedge rd_clk) disable iff (rrst)
    (rd_en && rd_empty) |=> ($stable(rptr) && $stable(rd_data)));
  a_r2_read_advance: assert property (@(posedge rd_clk) disable iff (rrst)
    (rd_en && !rd_empty) |=> (rptr == (RA+1)'($past(rptr) + 1'b1)));
  a_r6_level_bound: assert property (@(posedge rd_clk) disable iff (rrst)
    32'(rd_level) <= RDEPTH);
  a_r8_rgray_step: assert property (@(posedge rd_clk) disable iff (rrst)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: tb/test_cdc_mixed_fifo.sv
module test_cdc_mixed_fifo;
  localparam int WR_W = 32, RD_W = 8, WR_AW = 3, AF = 6, AE = 3;
  localparam int MIN_W = 8, WSL = 4, RSL = 1, DEPTH = 8, RA = 5;

  logic wr_clk = 0, rd_clk = 0, wr_rst = 1, rd_rst = 1, wr_en = 0, rd_en = 0;
  logic [WR_W-1:0] wr_data = '0;
  logic wr_full, wr_empty, wr_almost_full, rd_full, rd_empty, rd_almost_empty;
  logic [WR_AW:0] wr_level;
  logic [RA:0] rd_level;
  logic [RD_W-1:0] rd_data;

  int total = 0, bad = 0;
  logic [MIN_W-1:0] mdl[$];

  always #2 wr_clk = ~wr_clk;
  always #3.5 rd_clk = ~rd_clk;

  cdc_mixed_fifo i_cdc_mixed_fifo (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
    .wr_full(wr_full), .wr_empty(wr_empty), .wr_almost_full(wr_almost_full),
    .wr_level(wr_level), .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en),
    .rd_data(rd_data), .rd_full(rd_full), .rd_empty(rd_empty),
    .rd_almost_empty(rd_almost_empty), .rd_level(rd_level));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_wlev(int n); return (n + WSL - 1) / WSL; endfunction
  function automatic int exp_rlev(int n); return n / RSL; endfunction

  task automatic settle();
    repeat (8) @(negedge rd_clk);
    repeat (8) @(negedge wr_clk);
  endtask

  task automatic check_levels(string tag);
    int w, r;
    w = exp_wlev(mdl.size());
    r = exp_rlev(mdl.size());
    settle();
    @(negedge wr_clk);
    chk({"R5 wr_level ", tag}, 64'(wr_level), 64'(w));
    chk({"R5 wr_full ", tag}, 64'(wr_full), 64'(w == DEPTH));
    chk({"R8 wr_empty ", tag}, 64'(wr_empty), 64'(r == 0));
    chk({"R9 almost_full ", tag}, 64'(wr_almost_full), 64'(w >= AF));
    @(negedge rd_clk);
    chk({"R6 rd_level ", tag}, 64'(rd_level), 64'(r));
    chk({"R6 rd_empty ", tag}, 64'(rd_empty), 64'(r == 0));
    chk({"R7 rd_full ", tag}, 64'(rd_full), 64'(w == DEPTH));
    chk({"R10 almost_empty ", tag}, 64'(rd_almost_empty), 64'(r < AE));
  endtask

  task automatic wr_word(logic [WR_W-1:0] d, output bit acc);
    @(negedge wr_clk);
    acc = !wr_full;
    wr_en = 1; wr_data = d;
    @(negedge wr_clk);
    wr_en = 0;
    if (acc) for (int k = 0; k < WSL; k++) mdl.push_back(d[k*MIN_W +: MIN_W]);
  endtask

  task automatic rd_word(output bit acc);
    logic [RD_W-1:0] prev, exp;
    @(negedge rd_clk);
    acc = !rd_empty;
    prev = rd_data;
    rd_en = 1;
    @(negedge rd_clk);
    rd_en = 0;
    if (acc) begin
      for (int k = 0; k < RSL; k++) exp[k*MIN_W +: MIN_W] = mdl.pop_front();
      chk("R2 read data order", 64'(rd_data), 64'(exp));
    end else
      chk("R4 empty read keeps data", 64'(rd_data), 64'(prev));
  endtask

  initial begin
    #600000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit a;
    void'($urandom(32'd4242));
    repeat (3) @(negedge wr_clk);
    chk("R1 reset wr_level", 64'(wr_level), 0);
    chk("R1 reset rd_empty", 64'(rd_empty), 1);
    chk("R1 reset wr_full", 64'(wr_full), 0);
    wr_rst = 0; rd_rst = 0;
    settle();
    chk("R1 idle rd_level", 64'(rd_level), 0);
    chk("R1 idle wr_empty", 64'(wr_empty), 1);
    chk("R1 idle rd_full", 64'(rd_full), 0);
    chk("R1 idle almost_empty", 64'(rd_almost_empty), 1);
    chk("R1 idle almost_full", 64'(wr_almost_full), 0);

    rd_word(a);
    chk("R4 read on empty refused", 64'(a), 0);
    check_levels("after empty read");

    wr_word(32'h44332211, a);
    check_levels("one word");
    rd_word(a);
    chk("R2 first slice is 8'h11", 64'(rd_data), 64'h11);
    check_levels("partly read word");

    for (int i = 0; i < 7; i++) wr_word(32'hA0B0C0D0 + 32'(i), a);
    check_levels("filled");
    wr_word(32'hDEADBEEF, a);
    chk("R3 write while full refused", 64'(a), 0);
    check_levels("after refused write");

    while (mdl.size() > 0) rd_word(a);
    check_levels("drained");
    rd_word(a);
    chk("R4 read after drain refused", 64'(a), 0);

    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 1) == 1) wr_word($urandom(), a);
      else rd_word(a);
      if (i % 50 == 49) check_levels("random");
    end
    while (mdl.size() > 0) rd_word(a);
    check_levels("final");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule